// File: doc/BRIEF.md
# Three-Level Extended Physical Address Walker

This block turns a 32-bit linear address into a 36-bit physical address. It does this by walking translation tables in memory, and every entry in those tables is 64 bits wide. The linear address is cut into four fields, from the top down:

- a 2-bit root index,
- a 9-bit directory index,
- a 9-bit table index,
- a 12-bit byte offset.

The root index picks one of four root entries. That root entry names a directory, whose entry names a table, whose entry names the 4 KiB frame. A per-request large-page enable allows a walk to stop at the directory level. It stops there when the directory entry's size flag (bit 7) is set. The result is then a 2 MiB page, and the low 21 bits of the linear address pass through untranslated.

Requests enter on a valid/ready handshake. The walker takes a request only while idle, and samples the linear address, the large-page enable and the root base on that same edge. While a walk is in flight, `req_ready` is low and requests are held back. The memory side issues one 64-bit read per level, strictly in order, with a valid/ready request handshake. It keeps at most one read outstanding. The memory may stall a request for any number of cycles by holding `mem_req_ready` low. Read data returns later, with `mem_rd_valid`. The result is a single-cycle `rsp_done` (carrying `rsp_phys`) or `rsp_fault`. The result side has no back-pressure.

Top module: `lin_xlat_walker`

## Requirements
- R1: `req_ready` is high exactly when no walk is in progress. A request is taken on a clock edge with `req_valid` and `req_ready` both high. `req_lin`, `req_big_en` and `root_base` are sampled only on that edge.
- R2: The first read address is `{4'b0, root_base, lin[31:30], 3'b000}`. Here `root_base` holds address bits 31:5 of a 32-byte-aligned root table that lies in the lowest 4 GiB.
- R3: The second read address is `{root_entry[35:12], lin[29:21], 3'b000}`.
- R4: The third read address is `{dir_entry[35:12], lin[20:12], 3'b000}`.
- R5: After a three-read walk with all entries present, `rsp_phys = {tbl_entry[35:12], lin[11:0]}`. `rsp_done` is high in the cycle after the edge that delivers the last read data.
- R6: An entry whose present flag (bit 0) is clear ends the walk. `rsp_fault` pulses in the cycle after that data, and no further read is issued.
- R7: When `req_big_en` was sampled high and the present directory entry has bit 7 set, the walk ends after two reads with `rsp_phys = {dir_entry[35:21], lin[20:0]}`. Bits 20:12 of that entry are ignored.
- R8: When `req_big_en` was sampled low, bit 7 of the directory entry is ignored and the walk takes all three levels.
- R9: A memory request keeps `mem_req_valid` high and `mem_req_addr` stable until `mem_req_ready` is seen high. No new request is issued until the previous read's data has returned.
- R10: `rsp_done` and `rsp_fault` are never high together, and each stays high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_lin | input | 32 | Linear address to translate |
| req_big_en | input | 1 | Allow 2 MiB pages for this request |
| root_base | input | 27 | Root table address bits 31:5 |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 36 | Byte address of the 64-bit entry |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 64 | Entry read data |
| rsp_done | output | 1 | One-cycle translation success pulse |
| rsp_fault | output | 1 | One-cycle not-present fault pulse |
| rsp_phys | output | 36 | Physical address, meaningful with `rsp_done` |

## Verification
The bench builds the walker with its default parameters:

- a 32-bit linear address and 36-bit physical output,
- 9-bit indices,
- a 2-bit root index,
- a 12-bit offset.

These settings let random entries exercise all 24 frame bits, including the four above 4 GiB. They also let the 2 MiB path pass 21 offset bits. The root table fits in four entries, so every root slot is reached by random linear addresses. Memory stalls of zero to two cycles, on both the request handshake and the data return, probe the ordering and hold rules.

// File: rtl/pw_pkg.sv
package pw_pkg;
  // log2 of entry size in bytes (64-bit entries)
  localparam int ENT_LG = 3;
  // walk levels in the order they are read
  localparam logic [1:0] LV_ROOT = 2'd0;
  localparam logic [1:0] LV_DIR  = 2'd1;
  localparam logic [1:0] LV_TBL  = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } walk_st_e;
endpackage

// File: rtl/pw_entry_dec.sv
module pw_entry_dec #(
  parameter int ENT_W     = 64,
  parameter int PA_W      = 36,
  parameter int OFF_W     = 12,
  parameter int BIG_OFF_W = 21,
  parameter int PRES_BIT  = 0,
  parameter int SIZE_BIT  = 7
) (
  input  logic [ENT_W-1:0]          ent,
  output logic                      ent_present,
  output logic                      ent_size,
  output logic [PA_W-OFF_W-1:0]     ent_frame,
  output logic [PA_W-BIG_OFF_W-1:0] ent_big_base
);
  logic unused_ent_bits;

  assign ent_present     = ent[PRES_BIT];
  assign ent_size        = ent[SIZE_BIT];
  assign ent_frame       = ent[PA_W-1:OFF_W];
  assign ent_big_base    = ent[PA_W-1:BIG_OFF_W];
  assign unused_ent_bits = ^{ent[ENT_W-1:PA_W], ent[OFF_W-1:0]};
endmodule

// File: rtl/pw_addr_gen.sv
module pw_addr_gen
  import pw_pkg::*;
#(
  parameter int LIN_W = 32,
  parameter int PA_W  = 36,
  parameter int OFF_W = 12,
  parameter int IDX_W = 9,
  parameter int TOP_W = 2
) (
  input  logic [1:0]              lvl,
  input  logic [LIN_W-1:0]        lin,
  input  logic [LIN_W-TOP_W-ENT_LG-1:0] base,
  input  logic [PA_W-OFF_W-1:0]   frame,
  output logic [PA_W-1:0]         addr
);
  localparam int DIR_LSB = OFF_W + IDX_W;
  localparam int TOP_LSB = DIR_LSB + IDX_W;
  localparam int ROOT_W  = LIN_W;

  logic [ROOT_W-1:0] root_addr;
  logic              unused_lin_bits;

  assign root_addr       = {base, lin[TOP_LSB +: TOP_W], {ENT_LG{1'b0}}};
  assign unused_lin_bits = ^lin[OFF_W-1:0];

  always_comb begin
    case (lvl)
      LV_ROOT: addr = {{(PA_W-ROOT_W){1'b0}}, root_addr};
      LV_DIR:  addr = {frame, lin[DIR_LSB +: IDX_W], {ENT_LG{1'b0}}};
      LV_TBL:  addr = {frame, lin[OFF_W +: IDX_W], {ENT_LG{1'b0}}};
      default: addr = '0;
    endcase
  end
endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import pw_pkg::*;
#(
  parameter int LIN_W     = 32,
  parameter int PA_W      = 36,
  parameter int OFF_W     = 12,
  parameter int BIG_OFF_W = 21,
  parameter int BASE_W    = 27
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [LIN_W-1:0]          req_lin,
  input  logic                      req_big_en,
  input  logic [BASE_W-1:0]         root_base,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  input  logic                      mem_rd_valid,
  input  logic                      ent_present,
  input  logic                      ent_size,
  input  logic [PA_W-OFF_W-1:0]     ent_frame,
  input  logic [PA_W-BIG_OFF_W-1:0] ent_big_base,
  output logic [1:0]                lvl,
  output logic [LIN_W-1:0]          lin_q,
  output logic [BASE_W-1:0]         base_q,
  output logic [PA_W-OFF_W-1:0]     frame_q,
  output logic                      rsp_done,
  output logic                      rsp_fault,
  output logic [PA_W-1:0]           rsp_phys
);
  walk_st_e st;
  logic     big_q;
  logic     stop_big;

  assign req_ready     = (st == ST_IDLE);
  assign mem_req_valid = (st == ST_ISSUE);
  assign stop_big      = (lvl == LV_DIR) && big_q && ent_size;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      lvl       <= LV_ROOT;
      lin_q     <= '0;
      base_q    <= '0;
      big_q     <= 1'b0;
      frame_q   <= '0;
      rsp_done  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_phys  <= '0;
    end else begin
      rsp_done  <= 1'b0;
      rsp_fault <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          lin_q  <= req_lin;
          base_q <= root_base;
          big_q  <= req_big_en;
          lvl    <= LV_ROOT;
          st     <= ST_ISSUE;
        end
        ST_ISSUE: if (mem_req_ready) st <= ST_WAIT;
        ST_WAIT: if (mem_rd_valid) begin
          if (!ent_present) begin
            rsp_fault <= 1'b1;
            st        <= ST_IDLE;
          end else if (stop_big) begin
            rsp_done <= 1'b1;
            rsp_phys <= {ent_big_base, lin_q[BIG_OFF_W-1:0]};
            st       <= ST_IDLE;
          end else if (lvl == LV_TBL) begin
            rsp_done <= 1'b1;
            rsp_phys <= {ent_frame, lin_q[OFF_W-1:0]};
            st       <= ST_IDLE;
          end else begin
            frame_q <= ent_frame;
            lvl     <= lvl + 2'd1;
            st      <= ST_ISSUE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lin_xlat_walker.sv
module lin_xlat_walker
  import pw_pkg::*;
#(
  parameter int LIN_W    = 32,
  parameter int PA_W     = 36,
  parameter int ENT_W    = 64,
  parameter int OFF_W    = 12,
  parameter int IDX_W    = 9,
  parameter int TOP_W    = 2,
  parameter int PRES_BIT = 0,
  parameter int SIZE_BIT = 7
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic [LIN_W-1:0]                  req_lin,
  input  logic                              req_big_en,
  input  logic [LIN_W-TOP_W-ENT_LG-1:0]     root_base,
  output logic                              mem_req_valid,
  input  logic                              mem_req_ready,
  output logic [PA_W-1:0]                   mem_req_addr,
  input  logic                              mem_rd_valid,
  input  logic [ENT_W-1:0]                  mem_rd_data,
  output logic                              rsp_done,
  output logic                              rsp_fault,
  output logic [PA_W-1:0]                   rsp_phys
);
  localparam int BIG_OFF_W = OFF_W + IDX_W;
  localparam int BASE_W    = LIN_W - TOP_W - ENT_LG;
  localparam int FRM_W     = PA_W - OFF_W;
  localparam int BIG_W     = PA_W - BIG_OFF_W;

  logic             ent_present;
  logic             ent_size;
  logic [FRM_W-1:0] ent_frame;
  logic [BIG_W-1:0] ent_big_base;
  logic [1:0]       lvl;
  logic [LIN_W-1:0] lin_q;
  logic [BASE_W-1:0] base_q;
  logic [FRM_W-1:0] frame_q;

  pw_entry_dec #(
    .ENT_W(ENT_W), .PA_W(PA_W), .OFF_W(OFF_W), .BIG_OFF_W(BIG_OFF_W),
    .PRES_BIT(PRES_BIT), .SIZE_BIT(SIZE_BIT)
  ) u_dec (
    .ent(mem_rd_data), .ent_present(ent_present), .ent_size(ent_size),
    .ent_frame(ent_frame), .ent_big_base(ent_big_base)
  );

  pw_addr_gen #(
    .LIN_W(LIN_W), .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TOP_W(TOP_W)
  ) u_addr (
    .lvl(lvl), .lin(lin_q), .base(base_q), .frame(frame_q), .addr(mem_req_addr)
  );

  pw_ctrl #(
    .LIN_W(LIN_W), .PA_W(PA_W), .OFF_W(OFF_W), .BIG_OFF_W(BIG_OFF_W), .BASE_W(BASE_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
    .req_big_en(req_big_en), .root_base(root_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_rd_valid(mem_rd_valid),
    .ent_present(ent_present), .ent_size(ent_size), .ent_frame(ent_frame),
    .ent_big_base(ent_big_base),
    .lvl(lvl), .lin_q(lin_q), .base_q(base_q), .frame_q(frame_q),
    .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_phys(rsp_phys)
  );
endmodule

// File: rtl/pw_chk.sv
module pw_chk #(
  parameter int PA_W  = 36,
  parameter int LIN_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            mem_rd_valid,
  input logic            rsp_done,
  input logic            rsp_fault
);
  // R9
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R10
  excl_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_done && rsp_fault));

  // R10
  pulse_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done || rsp_fault) |=> !(rsp_done || rsp_fault));

  // R1
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R6
  fault_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> $past(mem_rd_valid));

  // R5
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(mem_rd_valid));

  // R2
  root_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_ready) |-> mem_req_valid && mem_req_addr[PA_W-1:LIN_W] == '0);
endmodule

bind lin_xlat_walker pw_chk #(.PA_W(PA_W), .LIN_W(LIN_W)) u_pw_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rd_valid(mem_rd_valid),
  .rsp_done(rsp_done), .rsp_fault(rsp_fault)
);

// File: tb/test_lin_xlat_walker.sv
module test_lin_xlat_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_lin = '0;
  logic        req_big_en = 1'b0;
  logic [26:0] root_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [35:0] mem_req_addr;
  logic        mem_rd_valid = 1'b0;
  logic [63:0] mem_rd_data = '0;
  logic        rsp_done;
  logic        rsp_fault;
  logic [35:0] rsp_phys;

  int total = 0;
  int bad = 0;
  bit ended = 1'b0;

  always #10 clk = ~clk;

  lin_xlat_walker i_lin_xlat_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_lin(req_lin), .req_big_en(req_big_en), .root_base(root_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .rsp_done(rsp_done), .rsp_fault(rsp_fault),
    .rsp_phys(rsp_phys)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [35:0] exp_addr(input int l, input logic [31:0] lin,
      input logic [26:0] base, input logic [63:0] e0, input logic [63:0] e1);
    if (l == 0) return {4'b0, base, lin[31:30], 3'b000};
    if (l == 1) return {e0[35:12], lin[29:21], 3'b000};
    return {e1[35:12], lin[20:12], 3'b000};
  endfunction

  task automatic walk(input logic [31:0] lin, input bit big, input logic [26:0] base,
                      input logic [63:0] e0, input logic [63:0] e1, input logic [63:0] e2,
                      input int stall);
    int nrd;
    bit flt;
    logic [35:0] ephys;
    logic [35:0] ea;
    logic [63:0] ent;
    string tag;
    string atag;
    ephys = '0;
    nrd = 1;
    flt = !e0[0];
    tag = "R6";
    if (e0[0]) begin
      nrd = 2;
      if (!e1[0]) flt = 1'b1;
      else if (big && e1[7]) begin
        ephys = {e1[35:21], lin[20:0]};
        tag = "R7";
      end else begin
        nrd = 3;
        flt = !e2[0];
        ephys = {e2[35:12], lin[11:0]};
        tag = flt ? "R6" : ((!big && e1[7]) ? "R8" : "R5");
      end
    end
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready when idle", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_lin = lin; req_big_en = big; root_base = base;
    @(negedge clk);
    // scramble after acceptance: R1 sampling only on the accept edge
    req_valid = 1'b0; req_lin = $urandom; req_big_en = ~big; root_base = 27'($urandom);
    for (int l = 0; l < nrd; l++) begin
      for (int t = 0; t < 20 && !mem_req_valid; t++) @(negedge clk);
      ea = exp_addr(l, lin, base, e0, e1);
      atag = (l == 0) ? "R2" : ((l == 1) ? "R3" : "R4");
      chk(mem_req_valid == 1'b1, atag, "read issued", 64'(mem_req_valid), 64'd1);
      chk(mem_req_addr == ea, atag, "read address", 64'(mem_req_addr), 64'(ea));
      chk(req_ready == 1'b0, "R1", "busy not ready", 64'(req_ready), 64'd0);
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(mem_req_valid && mem_req_addr == ea, "R9", "held request",
            64'(mem_req_addr), 64'(ea));
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      for (int s = 0; s < stall; s++) @(negedge clk);
      chk(mem_req_valid == 1'b0, "R9", "one outstanding", 64'(mem_req_valid), 64'd0);
      ent = (l == 0) ? e0 : ((l == 1) ? e1 : e2);
      mem_rd_valid = 1'b1; mem_rd_data = ent;
      @(negedge clk);
      mem_rd_valid = 1'b0; mem_rd_data = {$urandom, $urandom};
      if (l < nrd - 1)
        chk(!rsp_done && !rsp_fault, "R10", "no early result",
            64'({rsp_done, rsp_fault}), 64'd0);
    end
    if (flt) begin
      chk(rsp_fault && !rsp_done, "R6", "fault pulse", 64'({rsp_done, rsp_fault}), 64'd1);
    end else begin
      chk(rsp_done && !rsp_fault, tag, "done pulse", 64'({rsp_done, rsp_fault}), 64'd2);
      chk(rsp_phys == ephys, tag, "physical address", 64'(rsp_phys), 64'(ephys));
    end
    @(negedge clk);
    chk(!rsp_done && !rsp_fault, "R10", "single cycle result",
        64'({rsp_done, rsp_fault}), 64'd0);
    for (int k = 0; k < 2; k++) begin
      chk(!mem_req_valid, flt ? "R6" : tag, "no extra read", 64'(mem_req_valid), 64'd0);
      @(negedge clk);
    end
  endtask

  function automatic logic [63:0] rnd_ent();
    logic [63:0] e;
    e = {$urandom, $urandom};
    e[0] = ($urandom % 8) != 0;
    return e;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      total++; bad++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R1, R10)
    chk(req_ready == 1'b1, "R1", "reset ready", 64'(req_ready), 64'd1);
    chk(!mem_req_valid, "R9", "reset no read", 64'(mem_req_valid), 64'd0);
    chk(!rsp_done && !rsp_fault, "R10", "reset no result", 64'({rsp_done, rsp_fault}), 64'd0);
    // directed corner cases
    walk(32'hFFFF_FFFF, 1'b0, 27'h7FF_FFFF, 64'hFFFF_FFFF_FFFF_FF7F,
         64'hFFFF_FFFF_FFFF_FF7F, 64'hFFFF_FFFF_FFFF_FFFF, 1);     // R5 all ones
    walk(32'h0000_0000, 1'b0, 27'h000_0001, 64'h0000_0000_0000_1001,
         64'h0000_0000_0000_2001, 64'h0000_000F_0000_0001, 0);     // R5 top frame bits
    walk(32'h4012_3456, 1'b0, 27'h123_4567, 64'h0, 64'h1, 64'h1, 2); // R6 root
    walk(32'h8765_4321, 1'b1, 27'h0AB_CDEF, 64'h0000_0001_2345_6001,
         64'h0000_0000_0000_0080, 64'h1, 0);                       // R6 directory
    walk(32'hC000_0FFF, 1'b0, 27'h000_0000, 64'h0000_0002_0000_0001,
         64'h0000_0003_0000_0001, 64'h0000_000A_BCDE_F000, 1);     // R6 table
    walk(32'h3FFF_FFFF, 1'b1, 27'h555_5555, 64'h0000_0004_0000_0001,
         64'hFFFF_FFFF_FFFF_FF81, 64'h0, 2);                       // R7 junk in 20:12
    walk(32'h1234_5678, 1'b0, 27'h2AA_AAAA, 64'h0000_0004_0000_0001,
         64'h0000_0007_7770_0081, 64'h0000_0009_9999_9001, 0);     // R8 size bit ignored
    walk(32'h2468_ACE0, 1'b1, 27'h000_0F0F, 64'h0000_0004_0000_0001,
         64'h0000_0007_7770_0001, 64'h0000_0001_1111_1001, 1);     // R5 enable but 4 KiB
    walk(32'h2468_ACE0, 1'b1, 27'h000_0F0F, 64'h0000_0004_0000_0001,
         64'h0000_0007_7770_0080, 64'h1, 0);                       // R6 size set, absent
    // constrained random
    for (int n = 0; n < 300; n++) begin
      walk($urandom, 1'($urandom), 27'($urandom), rnd_ent(), rnd_ent(), rnd_ent(),
           int'($urandom % 3));
    end
    ended = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule